// File: doc/BRIEF.md
# Initial Program Load Sequencer

This block sits in front of a channel and brings up a machine that has no stored program yet. When a load request arrives, it builds a first read command in hardware rather than fetching it from memory. That command copies the first block of the chosen device into the 24-byte area at address 0. The block then fetches command words from the fixed addresses 8 and 16 and passes them to the channel. They read further bootstrap text. When that chain ends, the block reads the doubleword at address 0 back as the program status word (PSW). It then either starts the CPU from it or reports a wait state. An error ending from any command stops the load and raises a failure flag.

Two interfaces use valid/ready. The command interface to the channel holds `cmd_valid` and every command field steady until the channel raises `cmd_ready`. The memory read request interface holds `mem_req_valid` and `mem_req_addr` until `mem_req_ready`. The channel's ending status (`end_valid`) and the memory response (`mem_rsp_valid`) are one-cycle strobes with no back-pressure. The block takes them only while it is waiting for them and ignores them at any other time.

A command word is 64 bits: code in [63:56], data address in [55:32], command-chain flag at bit 30, length-suppress flag at bit 29, and byte count in [15:0]. In the PSW, bit 49 set means a wait-state word.

Top module: `ipl_sequencer`

## Requirements
- R1: After reset, `ipl_busy`, `cmd_valid`, `mem_req_valid`, `cpu_start`, `ipl_fail` and `wait_state` are all 0.
- R2: An `ipl_req` taken while idle raises `ipl_busy` and issues a command with code 0x02, address 0, count 24, chain and length-suppress both 1, and `cmd_dev` equal to the `dev_sel` value sampled with the request.
- R3: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` stays 1 and every command field stays unchanged. After the accepting cycle, `cmd_valid` falls.
- R4: A normal end of the implied command causes a memory read of address 8. The word returned is issued as the next command with the code, address, count, chain bit (30) and suppress bit (29) taken from it.
- R5: After a normal end of the command from address 8, the block reads address 16 if that word's bit 30 is 1, and reads address 0 otherwise. After the command from address 16, the next read is always address 0, whatever its chain bit.
- R6: The word read from address 0 appears on `psw_out`. If its bit 49 is 0, `cpu_start` is high for exactly one cycle, the second cycle after the response, and `ipl_busy` is 0 from that cycle on.
- R7: If the PSW bit 49 is 1, `wait_state` rises in that same cycle and stays 1, and `cpu_start` stays 0.
- R8: An `end_valid` with `end_err` = 1 for any command in the load sets `ipl_fail` in the next cycle and returns the block to idle. No further command, memory read or `cpu_start` follows.
- R9: An `ipl_req` is ignored while `ipl_busy` is 1, including in the cycles where the PSW response and the start/wait outcome are handled. `cmd_dev` and the command sequence are unaffected.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, `mem_req_valid` and `mem_req_addr` stay unchanged.
- R11: A newly accepted `ipl_req` clears `ipl_fail` and `wait_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ipl_req | input | 1 | Load request |
| dev_sel | input | DEV_W | Device to load from |
| cmd_valid | output | 1 | Command offered to channel |
| cmd_ready | input | 1 | Channel accepts command |
| cmd_dev | output | DEV_W | Target device of command |
| cmd_code | output | 8 | Command code |
| cmd_addr | output | ADDR_W | Data address |
| cmd_count | output | 16 | Byte count |
| cmd_chain | output | 1 | Command chaining flag |
| cmd_sli | output | 1 | Suppress incorrect-length flag |
| end_valid | input | 1 | Channel ending status strobe |
| end_err | input | 1 | Ending status is an error |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Read address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Read data |
| cpu_start | output | 1 | One-cycle CPU start pulse |
| psw_out | output | 64 | Loaded status word |
| ipl_busy | output | 1 | Load sequence active |
| ipl_fail | output | 1 | Load ended on error (sticky) |
| wait_state | output | 1 | Loaded PSW is a wait word (sticky) |

## Verification
Two events can fall in the same cycle: a fresh load request, and the PSW return together with the start/wait decision. The bench raises `ipl_req` on the cycle the PSW response strobe arrives and keeps it raised through the next cycle, which is the cycle in which the outcome is decided. The outcome must then appear on time with the correct PSW, and no new implied command may follow. A second request with a different device is also sent between a command's acceptance and its ending status. Every later command must still carry the original device.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int WORD_W     = 64;
  localparam int CNT_W      = 16;
  localparam int CHAIN_BIT  = 30;
  localparam int SLI_BIT    = 29;
  localparam int WAIT_BIT   = 49;
  localparam logic [7:0] IMPLIED_CODE = 8'h02;
  localparam int IMPLIED_CNT  = 24;
  localparam int FIRST_CCW_AD = 8;
  localparam int SECOND_CCW_AD = 16;
  localparam int PSW_AD       = 0;

  typedef struct packed {
    logic [7:0]       code;
    logic [23:0]      addr;
    logic             chain;
    logic             sli;
    logic [CNT_W-1:0] count;
  } ccw_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_END, S_FETCH, S_PSW, S_DONE
  } seq_state_t;

  function automatic ccw_t decode_ccw(input logic [WORD_W-1:0] w);
    ccw_t c;
    c.code  = w[63:56];
    c.addr  = w[55:32];
    c.chain = w[CHAIN_BIT];
    c.sli   = w[SLI_BIT];
    c.count = w[CNT_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/ipl_cmd_stage.sv
module ipl_cmd_stage
  import ipl_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DEV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_implied,
  input  logic              load_fetched,
  input  ccw_t              fetched,
  input  logic [DEV_W-1:0]  dev,
  input  logic              ready,
  output logic              valid,
  output logic              accept,
  output logic [DEV_W-1:0]  o_dev,
  output logic [7:0]        o_code,
  output logic [ADDR_W-1:0] o_addr,
  output logic [CNT_W-1:0]  o_count,
  output logic              o_chain,
  output logic              o_sli
);
  assign accept = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      o_dev   <= '0;
      o_code  <= '0;
      o_addr  <= '0;
      o_count <= '0;
      o_chain <= 1'b0;
      o_sli   <= 1'b0;
    end else if (load_implied) begin
      valid   <= 1'b1;
      o_dev   <= dev;
      o_code  <= IMPLIED_CODE;
      o_addr  <= ADDR_W'(PSW_AD);
      o_count <= CNT_W'(IMPLIED_CNT);
      o_chain <= 1'b1;
      o_sli   <= 1'b1;
    end else if (load_fetched) begin
      valid   <= 1'b1;
      o_code  <= fetched.code;
      o_addr  <= ADDR_W'(fetched.addr);
      o_count <= fetched.count;
      o_chain <= fetched.chain;
      o_sli   <= fetched.sli;
    end else if (accept) begin
      valid   <= 1'b0;
    end
  end

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(o_code) && $stable(o_addr) &&
                           $stable(o_count) && $stable(o_chain) &&
                           $stable(o_sli) && $stable(o_dev)));
  // R3
  cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !load_implied && !load_fetched) |=> !valid);
endmodule

// File: rtl/ipl_mem_port.sv
module ipl_mem_port #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              req_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              done
);
  logic waiting;

  assign done = waiting && rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
      waiting   <= 1'b0;
    end else begin
      if (start) begin
        req_valid <= 1'b1;
        req_addr  <= start_addr;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
        waiting   <= 1'b1;
      end
      if (done) waiting <= 1'b0;
    end
  end

  // R10
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
endmodule

// File: rtl/ipl_fsm.sv
module ipl_fsm
  import ipl_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DEV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ipl_req,
  input  logic [DEV_W-1:0]  dev_sel,
  output logic [DEV_W-1:0]  dev_q,
  output logic              load_implied,
  output logic              load_fetched,
  input  logic              cmd_accept,
  input  logic              end_valid,
  input  logic              end_err,
  output logic              mem_start,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_done,
  input  logic [WORD_W-1:0] mem_data,
  output logic              cpu_start,
  output logic [WORD_W-1:0] psw_q,
  output logic              busy,
  output logic              fail,
  output logic              wait_st
);
  seq_state_t state;
  logic [1:0] idx;
  logic       chain_q;
  logic       want_ccw;
  logic       end_ok;

  assign busy         = (state != S_IDLE);
  assign load_implied = (state == S_IDLE) && ipl_req;
  assign load_fetched = (state == S_FETCH) && mem_done;
  assign end_ok       = (state == S_END) && end_valid && !end_err;
  assign want_ccw     = (idx == 2'd0) || ((idx == 2'd1) && chain_q);
  assign mem_start    = end_ok;
  assign mem_addr     = !want_ccw ? ADDR_W'(PSW_AD) :
                        (idx == 2'd0) ? ADDR_W'(FIRST_CCW_AD) : ADDR_W'(SECOND_CCW_AD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      chain_q   <= 1'b0;
      dev_q     <= '0;
      psw_q     <= '0;
      cpu_start <= 1'b0;
      fail      <= 1'b0;
      wait_st   <= 1'b0;
    end else begin
      cpu_start <= 1'b0;
      case (state)
        S_IDLE: if (ipl_req) begin
          dev_q   <= dev_sel;
          idx     <= '0;
          chain_q <= 1'b1;
          fail    <= 1'b0;
          wait_st <= 1'b0;
          state   <= S_CMD;
        end
        S_CMD: if (cmd_accept) state <= S_END;
        S_END: if (end_valid) begin
          if (end_err) begin
            fail  <= 1'b1;
            state <= S_IDLE;
          end else if (want_ccw) begin
            state <= S_FETCH;
          end else begin
            state <= S_PSW;
          end
        end
        S_FETCH: if (mem_done) begin
          chain_q <= mem_data[CHAIN_BIT];
          idx     <= idx + 2'd1;
          state   <= S_CMD;
        end
        S_PSW: if (mem_done) begin
          psw_q <= mem_data;
          state <= S_DONE;
        end
        S_DONE: begin
          if (psw_q[WAIT_BIT]) wait_st <= 1'b1;
          else                 cpu_start <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start |=> !cpu_start);
  // R6
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start |-> (!busy && !psw_q[WAIT_BIT]));
  // R7
  wait_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_st |-> !cpu_start);
  // R8
  fail_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!cpu_start && !mem_start));
  // R9
  busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ipl_req) |=> $stable(dev_q));
endmodule

// File: rtl/ipl_sequencer.sv
module ipl_sequencer
  import ipl_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DEV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ipl_req,
  input  logic [DEV_W-1:0]  dev_sel,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DEV_W-1:0]  cmd_dev,
  output logic [7:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [15:0]       cmd_count,
  output logic              cmd_chain,
  output logic              cmd_sli,
  input  logic              end_valid,
  input  logic              end_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              cpu_start,
  output logic [63:0]       psw_out,
  output logic              ipl_busy,
  output logic              ipl_fail,
  output logic              wait_state
);
  logic [DEV_W-1:0]  dev_q;
  logic              load_implied, load_fetched, cmd_accept;
  logic              mem_start, mem_done;
  logic [ADDR_W-1:0] mem_addr;
  ccw_t              fetched;

  assign fetched = decode_ccw(mem_rsp_data);

  ipl_fsm #(.ADDR_W(ADDR_W), .DEV_W(DEV_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ipl_req(ipl_req), .dev_sel(dev_sel),
    .dev_q(dev_q), .load_implied(load_implied), .load_fetched(load_fetched),
    .cmd_accept(cmd_accept), .end_valid(end_valid), .end_err(end_err),
    .mem_start(mem_start), .mem_addr(mem_addr), .mem_done(mem_done),
    .mem_data(mem_rsp_data), .cpu_start(cpu_start), .psw_q(psw_out),
    .busy(ipl_busy), .fail(ipl_fail), .wait_st(wait_state)
  );

  ipl_cmd_stage #(.ADDR_W(ADDR_W), .DEV_W(DEV_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load_implied(load_implied),
    .load_fetched(load_fetched), .fetched(fetched), .dev(dev_sel),
    .ready(cmd_ready), .valid(cmd_valid), .accept(cmd_accept),
    .o_dev(cmd_dev), .o_code(cmd_code), .o_addr(cmd_addr),
    .o_count(cmd_count), .o_chain(cmd_chain), .o_sli(cmd_sli)
  );

  ipl_mem_port #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .start(mem_start), .start_addr(mem_addr),
    .req_ready(mem_req_ready), .req_valid(mem_req_valid),
    .req_addr(mem_req_addr), .rsp_valid(mem_rsp_valid), .done(mem_done)
  );

  // R2
  implied_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ipl_busy && ipl_req) |=> (cmd_valid && ipl_busy && cmd_code == IMPLIED_CODE &&
                                cmd_addr == '0 && cmd_chain && cmd_sli));
  // R9
  busy_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_busy && ipl_req && !load_fetched) |=> $stable(cmd_dev));
  // R5
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, mem_req_valid}));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ipl_busy |-> (!cmd_valid && !mem_req_valid));
endmodule

// File: tb/test_ipl_sequencer.sv
module test_ipl_sequencer;
  localparam int ADDR_W = 24;
  localparam int DEV_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ipl_req = 1'b0;
  logic [DEV_W-1:0] dev_sel = '0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [DEV_W-1:0] cmd_dev;
  logic [7:0] cmd_code;
  logic [ADDR_W-1:0] cmd_addr;
  logic [15:0] cmd_count;
  logic cmd_chain, cmd_sli;
  logic end_valid = 1'b0, end_err = 1'b0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic cpu_start;
  logic [63:0] psw_out;
  logic ipl_busy, ipl_fail, wait_state;

  int n_total = 0;
  int n_fail  = 0;
  int n_starts = 0;

  always #5 clk = ~clk;

  ipl_sequencer #(.ADDR_W(ADDR_W), .DEV_W(DEV_W)) i_ipl_sequencer (
    .clk(clk), .rst_n(rst_n), .ipl_req(ipl_req), .dev_sel(dev_sel),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dev(cmd_dev),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .cmd_chain(cmd_chain), .cmd_sli(cmd_sli), .end_valid(end_valid),
    .end_err(end_err), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cpu_start(cpu_start), .psw_out(psw_out), .ipl_busy(ipl_busy),
    .ipl_fail(ipl_fail), .wait_state(wait_state)
  );

  always @(negedge clk) if (rst_n && cpu_start) n_starts++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_ccw(input logic [7:0] code, input logic [23:0] a,
                                         input bit chain, input bit sli, input logic [15:0] cnt);
    return {code, a, 1'b0, chain, sli, 13'b0, cnt};
  endfunction

  task automatic wait_cmd(output bit ok);
    ok = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (cmd_valid) begin ok = 1; break; end
    end
  endtask

  task automatic wait_mem(output bit ok);
    ok = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (mem_req_valid) begin ok = 1; break; end
    end
  endtask

  // offers a command, checks fields and hold, accepts, then returns ending status
  task automatic take_cmd(input logic [7:0] code, input logic [23:0] a, input logic [15:0] cnt,
                          input bit chain, input bit sli, input logic [DEV_W-1:0] dev,
                          input int dly, input bit err, input bit poke);
    bit ok;
    wait_cmd(ok);
    chk(ok, "R4", "command offered", 64'(cmd_valid), 64'd1);
    chk(cmd_code == code, (code == 8'h02) ? "R2" : "R4", "cmd code", 64'(cmd_code), 64'(code));
    chk(cmd_addr == a, "R4", "cmd addr", 64'(cmd_addr), 64'(a));
    chk(cmd_count == cnt, "R4", "cmd count", 64'(cmd_count), 64'(cnt));
    chk(cmd_chain == chain && cmd_sli == sli, "R4", "cmd flags",
        64'({cmd_chain, cmd_sli}), 64'({chain, sli}));
    chk(cmd_dev == dev, "R9", "cmd dev", 64'(cmd_dev), 64'(dev));
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(cmd_valid && cmd_code == code && cmd_addr == a && cmd_count == cnt,
          "R3", "hold under back-pressure", 64'(cmd_valid), 64'd1);
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk(!cmd_valid, "R3", "valid drops after accept", 64'(cmd_valid), 64'd0);
    if (poke) begin
      ipl_req = 1'b1; dev_sel = ~dev;
      @(negedge clk);
      ipl_req = 1'b0; dev_sel = dev;
    end
    end_valid = 1'b1; end_err = err;
    @(negedge clk);
    end_valid = 1'b0; end_err = 1'b0;
  endtask

  task automatic serve_mem(input logic [23:0] a, input logic [63:0] data, input int dly,
                           input string req);
    bit ok;
    wait_mem(ok);
    chk(ok && mem_req_addr == a, req, "read address", 64'(mem_req_addr), 64'(a));
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == a, "R10", "request hold", 64'(mem_req_addr), 64'(a));
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = data;
  endtask

  task automatic check_fail_quiet;
    chk(ipl_fail && !ipl_busy, "R8", "fail flag after error end",
        64'({ipl_fail, ipl_busy}), 64'b10);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!cmd_valid && !mem_req_valid && !cpu_start, "R8", "quiet after failure",
          64'({cmd_valid, mem_req_valid, cpu_start}), 64'd0);
    end
  endtask

  initial begin
    #1ms;
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ipl_busy && !cmd_valid && !mem_req_valid && !cpu_start && !ipl_fail && !wait_state,
        "R1", "reset outputs",
        64'({ipl_busy, cmd_valid, mem_req_valid, cpu_start, ipl_fail, wait_state}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int r = 0; r < 16; r++) begin
      bit chain8 = r[0];
      bit waitb  = r[1];
      int err_at = r / 4;           // 0 none, 1 implied, 2 first fetched, 3 second fetched
      int dly    = r % 3;
      logic [DEV_W-1:0] dev = DEV_W'(r + 3);
      logic [63:0] c8  = mk_ccw(8'h06, 24'h1000 + 24'(r * 16), chain8, 1'b1, 16'd80 + 16'(r));
      logic [63:0] c16 = mk_ccw(8'h0E, 24'h2000 + 24'(r), r[1], 1'b0, 16'd3000 + 16'(r));
      logic [63:0] psw = 64'hA5A5_0000_0000_1000 + 64'(r);
      int starts0;
      psw[49] = waitb;

      ipl_req = 1'b1; dev_sel = dev;
      @(negedge clk);
      ipl_req = 1'b0;
      chk(ipl_busy, "R2", "busy after request", 64'(ipl_busy), 64'd1);
      // R11: previous outcome flags cleared
      chk(!ipl_fail && !wait_state, "R11", "flags cleared on new load",
          64'({ipl_fail, wait_state}), 64'd0);

      take_cmd(8'h02, 24'd0, 16'd24, 1'b1, 1'b1, dev, dly, err_at == 1, 1'b1);
      if (err_at == 1) begin check_fail_quiet(); continue; end

      serve_mem(24'd8, c8, dly, "R4");
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      take_cmd(c8[63:56], c8[55:32], c8[15:0], chain8, 1'b1, dev, dly, err_at == 2, 1'b0);
      if (err_at == 2) begin check_fail_quiet(); continue; end

      if (chain8) begin
        serve_mem(24'd16, c16, dly, "R5");
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        take_cmd(c16[63:56], c16[55:32], c16[15:0], r[1], 1'b0, dev, dly, err_at == 3, 1'b0);
        if (err_at == 3) begin check_fail_quiet(); continue; end
      end

      // R5: chain ends, PSW fetched from address 0
      serve_mem(24'd0, psw, dly, "R5");
      starts0 = n_starts;
      ipl_req = 1'b1; dev_sel = ~dev;   // R9: request alongside PSW return
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk(!cpu_start, "R6", "no start before outcome cycle", 64'(cpu_start), 64'd0);
      @(negedge clk);
      ipl_req = 1'b0; dev_sel = dev;
      chk(cpu_start == !waitb, waitb ? "R7" : "R6", "start pulse", 64'(cpu_start), 64'(!waitb));
      chk(wait_state == waitb, "R7", "wait flag", 64'(wait_state), 64'(waitb));
      chk(psw_out == psw, "R6", "psw value", psw_out, psw);
      chk(!ipl_busy, "R6", "idle at outcome", 64'(ipl_busy), 64'd0);
      @(negedge clk);
      chk(!cpu_start, "R6", "single-cycle start", 64'(cpu_start), 64'd0);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(!cmd_valid && !ipl_busy, "R9", "overlapping request ignored",
            64'({cmd_valid, ipl_busy}), 64'd0);
      end
      chk(n_starts - starts0 == (waitb ? 0 : 1), "R7", "start pulse count",
          64'(n_starts - starts0), 64'(waitb ? 0 : 1));
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule